// File: doc/BRIEF.md
# Watchdog Timer with Shared Timer Prescaler

This block combines an 8-bit general-purpose timer with a watchdog. The two share one 8-bit prescaler. A configuration bit connects the prescaler either after the watchdog base counter or before the timer. The side that does not own the prescaler bypasses it. The watchdog counts enable pulses from an independent free-running tick input. This input is separate from the instruction-clock tick, so the watchdog keeps counting while the core is asleep and its instruction ticks have stopped.

When the watchdog reaches its prescaled terminal count, it raises a one-cycle reset request. If the sleep input is high at that moment, it raises a one-cycle wake request instead. The same event drives an active-low time-out flag to 0. Software keeps the watchdog from firing with a clear strobe. The sleep-entry strobe has the same effect. The timer counts either instruction ticks or edges of an external pin, with the edge polarity selectable. Every count event passes through a two-stage synchronizer before it reaches the counter. When the counter wraps from 0xFF to 0x00 it sets an overflow flag.

Top module: `guard_watchdog`

## Requirements
- R1: After reset, the timer value is 0x00. The overflow flag is 0, to_n is 1, reset_req and wake_req are 0, and the configuration is: source = instruction tick, rising edge, prescaler on the watchdog, ratio 7.
- R2: The timer count source comes from cfg_wdata bit 5: 0 selects instr_tick, 1 selects ext_pin. Bit 4 selects the pin edge: 0 counts a low-to-high change between consecutive cycles, 1 counts a high-to-low change.
- R3: A count event seen in cycle t increments tmr_value at the third rising clock edge after the start of cycle t, because it passes two synchronizer stages. The value is visible in the cycle after that edge.
- R4: With cfg_wdata bit 3 = 0 (prescaler on the timer), ratio field n in bits 2:0 passes one in every 2^(n+1) source events to the timer.
- R5: The side that does not own the prescaler is not divided. With the prescaler on the watchdog, every source event counts the timer. With the prescaler on the timer, the watchdog times out once every WDT_TERM enabled ticks.
- R6: With the prescaler on the watchdog, ratio n gives one time-out every WDT_TERM * 2^n uninterrupted ticks.
- R7: A time-out produces a one-cycle pulse in the next cycle. The pulse is on reset_req when sleep is 0 and on wake_req when sleep is 1. The two are never high together.
- R8: clr_wdt or sleep_entry clears the watchdog base counter. It also clears the prescaler when the prescaler is on the watchdog. A strobe in the same cycle as the terminal tick wins, and no time-out occurs.
- R9: With wdt_en = 0 the base counter stays at 0 and no time-out occurs.
- R10: to_n drops to 0 in the cycle after a time-out. It returns to 1 after a clear or sleep-entry strobe and after reset. It has no write path.
- R11: An increment from 0xFF to 0x00 sets tmr_flag. flag_clr clears it. If both happen in the same cycle, setting wins.
- R12: tmr_we loads tmr_wdata into the timer in the next cycle. A load in the same cycle as a pending increment wins, and that increment is dropped.
- R13: A configuration write that moves the prescaler to the other side clears the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| wdt_tick | input | 1 | Independent watchdog tick enable |
| sleep | input | 1 | System is in sleep |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_entry | input | 1 | Sleep-entry strobe |
| instr_tick | input | 1 | Instruction-clock tick enable |
| ext_pin | input | 1 | External timer pin, synchronous to clk |
| cfg_we | input | 1 | Configuration write |
| cfg_wdata | input | 6 | {pin source, falling edge, prescaler on watchdog, ratio[2:0]} |
| tmr_we | input | 1 | Timer load |
| tmr_wdata | input | TMR_W | Timer load value |
| flag_clr | input | 1 | Overflow flag clear |
| tmr_value | output | TMR_W | Timer count |
| tmr_flag | output | 1 | Timer overflow flag |
| reset_req | output | 1 | Watchdog reset request pulse |
| wake_req | output | 1 | Watchdog wake request pulse |
| to_n | output | 1 | Active-low time-out flag |

## Verification
A clear or sleep-entry strobe can land in the same cycle as the watchdog tick that would complete the terminal count. The bench provokes this by watching its own model's base count and raising the strobe only when the next tick is the terminal one. It judges the result by requiring that no reset or wake pulse follows and that to_n stays 1. A second coincidence is a timer overflow meeting flag_clr. The bench compares every output against the reference model on every cycle under random strobes, with both orderings covered.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int RATIO_W = 3;

    typedef struct packed {
        logic               src_ext;
        logic               edge_fall;
        logic               pre_to_wdt;
        logic [RATIO_W-1:0] ratio;
    } gcfg_t;

    localparam int CFG_W = $bits(gcfg_t);

    localparam gcfg_t CFG_RESET = '{
        src_ext:    1'b0,
        edge_fall:  1'b0,
        pre_to_wdt: 1'b1,
        ratio:      {RATIO_W{1'b1}}
    };
endpackage

// File: rtl/guard_evtsel.sv
module guard_evtsel (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic edge_fall,
    input  logic instr_tick,
    input  logic ext_pin,
    output logic src_evt
);
    typedef struct packed {
        logic pin_prev;
    } st_t;

    st_t  st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d          = st_q;
        st_d.pin_prev = ext_pin;
        rise          = ext_pin && !st_q.pin_prev;
        fall          = !ext_pin && st_q.pin_prev;
        src_evt       = src_ext ? (edge_fall ? fall : rise) : instr_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/guard_prescaler.sv
module guard_prescaler #(
    parameter int PRE_W   = 8,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_evt,
    input  logic               clr,
    input  logic               to_wdt,
    input  logic [RATIO_W-1:0] ratio,
    output logic               hit
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [PRE_W-1:0] mask;
    int               lim;

    // watchdog side divides by 2^n, timer side by 2^(n+1)
    always_comb begin
        lim = int'(ratio) + (to_wdt ? 0 : 1);
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < lim);
    end

    always_comb begin
        st_d = st_q;
        hit  = in_evt && ((st_q.cnt & mask) == mask);
        if (clr)         st_d.cnt = '0;
        else if (in_evt) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/guard_wdog.sv
module guard_wdog #(
    parameter int TERM = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic wrap
);
    localparam int BW = $clog2(TERM + 1);
    localparam logic [BW-1:0] LAST = BW'(TERM - 1);

    typedef struct packed {
        logic [BW-1:0] base;
    } st_t;

    st_t  st_d, st_q;
    logic at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.base == LAST);
        wrap   = en && !clr && tick && at_end;
        if (!en || clr) st_d.base = '0;
        else if (tick)  st_d.base = at_end ? '0 : st_q.base + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/guard_tmr.sv
module guard_tmr #(
    parameter int W      = 8,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         flag_clr,
    output logic [W-1:0] value,
    output logic         flag
);
    typedef struct packed {
        logic [SYNC_N-1:0] sh;
        logic [W-1:0]      cnt;
        logic              flag;
    } st_t;

    st_t               st_d, st_q;
    logic [SYNC_N-1:0] sh_next;
    logic              step, ovf;

    generate
        if (SYNC_N == 1) begin : g_one
            assign sh_next = evt;
        end else begin : g_many
            assign sh_next = {st_q.sh[SYNC_N-2:0], evt};
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.sh = sh_next;
        step    = st_q.sh[SYNC_N-1];
        ovf     = step && !we && (st_q.cnt == {W{1'b1}});
        if (we)        st_d.cnt = wdata;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;
        if (ovf)           st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;
    assign flag  = st_q.flag;
endmodule

// File: rtl/guard_watchdog.sv
module guard_watchdog
    import guard_pkg::*;
#(
    parameter int TMR_W    = 8,
    parameter int PRE_W    = 8,
    parameter int WDT_TERM = 16,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en,
    input  logic             wdt_tick,
    input  logic             sleep,
    input  logic             clr_wdt,
    input  logic             sleep_entry,
    input  logic             instr_tick,
    input  logic             ext_pin,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] tmr_value,
    output logic             tmr_flag,
    output logic             reset_req,
    output logic             wake_req,
    output logic             to_n
);
    typedef struct packed {
        gcfg_t cfg;
        logic  to_n;
        logic  rst_req;
        logic  wake_req;
    } top_st_t;

    top_st_t st_d, st_q;
    gcfg_t   new_cfg;
    logic    wd_clr, psa, psa_flip;
    logic    src_evt, wrap, hit;
    logic    pre_in, pre_clr, timeout, tmr_evt;

    assign new_cfg  = gcfg_t'(cfg_wdata);
    assign wd_clr   = clr_wdt || sleep_entry;
    assign psa      = st_q.cfg.pre_to_wdt;
    assign psa_flip = cfg_we && (new_cfg.pre_to_wdt != psa);
    assign pre_in   = psa ? wrap : src_evt;
    assign pre_clr  = psa_flip || (psa && wd_clr);
    assign timeout  = psa ? hit : wrap;
    assign tmr_evt  = psa ? src_evt : hit;

    guard_evtsel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_ext    (st_q.cfg.src_ext),
        .edge_fall  (st_q.cfg.edge_fall),
        .instr_tick (instr_tick),
        .ext_pin    (ext_pin),
        .src_evt    (src_evt)
    );

    guard_wdog #(.TERM(WDT_TERM)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wdt_en),
        .tick  (wdt_tick),
        .clr   (wd_clr),
        .wrap  (wrap)
    );

    guard_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_evt (pre_in),
        .clr    (pre_clr),
        .to_wdt (psa),
        .ratio  (st_q.cfg.ratio),
        .hit    (hit)
    );

    guard_tmr #(.W(TMR_W), .SYNC_N(SYNC_N)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (tmr_evt),
        .we       (tmr_we),
        .wdata    (tmr_wdata),
        .flag_clr (flag_clr),
        .value    (tmr_value),
        .flag     (tmr_flag)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rst_req  = timeout && !sleep;
        st_d.wake_req = timeout && sleep;
        if (cfg_we) st_d.cfg = new_cfg;
        if (wd_clr)       st_d.to_n = 1'b1;
        else if (timeout) st_d.to_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg      <= CFG_RESET;
            st_q.to_n     <= 1'b1;
            st_q.rst_req  <= 1'b0;
            st_q.wake_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reset_req = st_q.rst_req;
    assign wake_req  = st_q.wake_req;
    assign to_n      = st_q.to_n;
endmodule

// File: rtl/guard_watchdog_chk.sv
module guard_watchdog_chk #(
    parameter int TMR_W = 8,
    parameter int CFG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_en,
    input logic             wdt_tick,
    input logic             sleep,
    input logic             clr_wdt,
    input logic             sleep_entry,
    input logic             instr_tick,
    input logic             ext_pin,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             tmr_we,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             flag_clr,
    input logic [TMR_W-1:0] tmr_value,
    input logic             tmr_flag,
    input logic             reset_req,
    input logic             wake_req,
    input logic             to_n
);
    assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && wake_req));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> !(reset_req || wake_req));

    assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt || sleep_entry) |=> (!(reset_req || wake_req) && to_n));

    assert_ton_falls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_n) |-> (reset_req || wake_req));

    assert_tmr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tmr_we)) |->
        ((tmr_value == $past(tmr_value)) || (tmr_value == $past(tmr_value) + 1'b1)));

    assert_wrap_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tmr_we) && ($past(tmr_value) == {TMR_W{1'b1}}) &&
         (tmr_value == '0)) |-> tmr_flag);
endmodule

bind guard_watchdog guard_watchdog_chk #(.TMR_W(TMR_W), .CFG_W(guard_pkg::CFG_W)) u_chk (.*);

// File: tb/sim_guard_watchdog.sv
module sim_guard_watchdog;
    localparam int TERM = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en = 1'b1, wdt_tick = 1'b0, sleep = 1'b0;
    logic       clr_wdt = 1'b0, sleep_entry = 1'b0, instr_tick = 1'b0, ext_pin = 1'b0;
    logic       cfg_we = 1'b0, tmr_we = 1'b0, flag_clr = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] tmr_value;
    logic       tmr_flag, reset_req, wake_req, to_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    guard_watchdog #(.WDT_TERM(TERM)) u0 (.*);

    // behavioural reference
    int   m_tmr = 0, m_pre = 0, m_base = 0;
    bit   m_flag = 0, m_ton = 1, m_rr = 0, m_wr = 0, m_prev = 0;
    bit   m_s1 = 0, m_s2 = 0;
    logic [5:0] m_cfg = 6'b001111;

    always @(posedge clk) begin
        bit psa, evt, clr, wrap, pin, hit, tout, tevt, step;
        int div;
        if (!rst_n) begin
            m_tmr = 0; m_pre = 0; m_base = 0; m_flag = 0; m_ton = 1;
            m_rr = 0; m_wr = 0; m_prev = 0; m_s1 = 0; m_s2 = 0; m_cfg = 6'b001111;
        end else begin
            psa  = m_cfg[3];
            evt  = m_cfg[5] ? (m_cfg[4] ? (m_prev && !ext_pin) : (!m_prev && ext_pin)) : instr_tick;
            clr  = clr_wdt || sleep_entry;
            wrap = wdt_en && !clr && wdt_tick && (m_base == TERM - 1);
            div  = psa ? (1 << m_cfg[2:0]) : (2 << m_cfg[2:0]);
            pin  = psa ? wrap : evt;
            hit  = pin && ((m_pre % div) == div - 1);
            tout = psa ? hit : wrap;
            tevt = psa ? evt : hit;
            step = m_s2;
            m_s2 = m_s1;
            m_s1 = tevt;
            m_prev = ext_pin;
            if (!wdt_en || clr) m_base = 0;
            else if (wdt_tick) m_base = (m_base == TERM - 1) ? 0 : m_base + 1;
            if (cfg_we && cfg_wdata[3] != psa) m_pre = 0;
            else if (psa && clr) m_pre = 0;
            else if (pin) m_pre = (m_pre + 1) % 256;
            if (tmr_we) m_tmr = tmr_wdata;
            else if (step) begin
                if (m_tmr == 255) m_flag = 1;
                m_tmr = (m_tmr + 1) % 256;
            end
            if (!(step && !tmr_we && m_tmr == 0) && flag_clr) m_flag = 0;
            m_rr = tout && !sleep;
            m_wr = tout && sleep;
            if (clr) m_ton = 1;
            else if (tout) m_ton = 0;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk("R3/R12 tmr_value", tmr_value, m_tmr);
            chk("R11 tmr_flag", tmr_flag, m_flag);
            chk("R7 reset_req", reset_req, m_rr);
            chk("R7 wake_req", wake_req, m_wr);
            chk("R10 to_n", to_n, m_ton);
        end
    endtask

    task automatic quiet();
        cfg_we = 0; tmr_we = 0; clr_wdt = 0; sleep_entry = 0; flag_clr = 0;
    endtask

    // random phase: cfg is written in the first cycle
    task automatic run_rand(input int n, input logic [5:0] cfg, input bit en, input int p_clr,
                            input int p_cfg);
        cyc();
        quiet();
        cfg_we = 1; cfg_wdata = cfg; wdt_en = en;
        for (int i = 0; i < n; i++) begin
            cyc();
            quiet();
            wdt_tick   = ($urandom_range(0, 3) != 0);
            instr_tick = ($urandom_range(0, 1) != 0);
            ext_pin    = ($urandom_range(0, 2) == 0) ? ~ext_pin : ext_pin;
            if ($urandom_range(0, 99) == 0) sleep = ~sleep;
            clr_wdt     = ($urandom_range(0, 999) < p_clr);
            sleep_entry = ($urandom_range(0, 999) < p_clr / 4);
            flag_clr    = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 199) == 0) begin
                tmr_we = 1; tmr_wdata = 8'hF0 + 8'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 999) < p_cfg) begin
                cfg_we = 1; cfg_wdata = 6'($urandom_range(0, 63));
            end
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 tmr_value", tmr_value, 0);
        chk("R1 tmr_flag", tmr_flag, 0);
        chk("R1 to_n", to_n, 1);
        chk("R1 reset_req", reset_req, 0);
        chk("R1 wake_req", wake_req, 0);
        // R6 default ratio 7 with prescaler on the watchdog, R5 timer undivided
        run_rand(2500, 6'b001111, 1'b1, 0, 0);
        // R5 R7 R10 prescaler on watchdog, ratio 0 and 2 (R6)
        run_rand(1500, 6'b001000, 1'b1, 4, 0);
        run_rand(2000, 6'b001010, 1'b1, 2, 0);
        // R4 prescaler on timer, watchdog bypass
        run_rand(1500, 6'b000000, 1'b1, 4, 0);
        run_rand(3000, 6'b000011, 1'b1, 4, 0);
        // R2 pin source, rising then falling
        run_rand(1500, 6'b101000, 1'b1, 4, 0);
        run_rand(1500, 6'b110000, 1'b1, 4, 0);
        // R9 watchdog disabled
        run_rand(1500, 6'b001000, 1'b0, 0, 0);
        // R13 reassignment under random writes, R12 R11 loads near wrap
        run_rand(4000, 6'b000001, 1'b1, 3, 20);
        // R8 strobe in the terminal-tick cycle
        cyc(); quiet(); cfg_we = 1; cfg_wdata = 6'b001000; wdt_en = 1; instr_tick = 0;
        hits = 0;
        for (int i = 0; i < 400 && hits < 8; i++) begin
            cyc();
            quiet();
            wdt_tick = 1;
            if (m_base == TERM - 1) begin
                if (hits[0]) sleep_entry = 1; else clr_wdt = 1;
                hits++;
            end
        end
        chk("R8 coincidences provoked", hits, 8);
        repeat (3) cyc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule